// File: doc/BRIEF.md
# Four-Channel Interrupt Aggregator

This block merges four active-low interrupt requests, one from each downstream bus channel, into a single active-low request line for the host. The line is low whenever any channel requests service. It stays low only as long as the request does, so it releases once the requesting device withdraws it. Every channel is watched at all times, including channels that are not selected.

The block also holds an 8-bit control byte. A host sees it through a simple register read/write port, which stands in for the serial-bus slave logic. The low bits hold the channel-select setting written by the host and drive the switch fabric. The high nibble holds a per-channel pending snapshot. That snapshot is refreshed on each read strobe, so the host can find which channel raised the interrupt and then select that channel to service it.

Each input passes through a two-flop synchronizer before it is used. The combined output therefore follows an input change after two clock edges.

Top module: `irq_fanin_agg`

## Requirements
- R1: After reset, `irq_no` is 1, `rd_data_o` is 0x00, `chan_en_o` is 0 and `chan_sel_o` is 0.
- R2: `irq_no` goes to 0 on the second rising clock edge after any `irq_ni` bit is sampled low, whatever the select setting. It is still 1 after only one edge.
- R3: The interrupt does not latch. `irq_no` returns to 1 on the second rising edge after all `irq_ni` bits are sampled high, with no read needed.
- R4: A rising edge with `rd_en_i` high loads `rd_data_o[4+k]` with 1 if channel k's synchronized input is low, and with 0 otherwise (k = 0..3).
- R5: Bits 7:4 of `rd_data_o` hold their value between read strobes, even while the inputs change.
- R6: A rising edge with `wr_en_i` high loads `wr_data_i[2:0]` into `rd_data_o[2:0]`. Bit 2 is the enable and bits 1:0 are the channel number. `wr_data_i[7:3]` are ignored, and `rd_data_o[3]` always reads 0.
- R7: `chan_en_o` equals select bit 2 and `chan_sel_o` equals select bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ni | input | 4 | Per-channel interrupt requests, active low |
| irq_no | output | 1 | Combined interrupt, active low |
| wr_en_i | input | 1 | Select-register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe; captures the pending snapshot |
| rd_data_o | output | 8 | Control byte: {pending[3:0], 0, enable, channel[1:0]} |
| chan_en_o | output | 1 | Switch enable to the fabric |
| chan_sel_o | output | 2 | Selected channel to the fabric |

## Verification
The latency properties assume that the interrupt inputs rest high (idle) for as long as reset is held. They look two edges back only after two edges have passed since reset was released. The bench keeps the inputs idle through every reset. It changes the inputs, the strobes and the write data only on falling edges, so each request is sampled cleanly by the synchronizer on the next rising edge. Read and write strobes last exactly one cycle, which matches the single-edge capture the snapshot and select properties expect.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NCH         = 4;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned BYTEW       = 8;
  localparam int unsigned CHW         = $clog2(NCH);
  localparam int unsigned SELW        = CHW + 1;
  localparam int unsigned PADW        = BYTEW - NCH - SELW;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  // reset to idle (high) so no false request appears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '1;
    else         stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '1;
      else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irq_status.sv
module irq_status
  import irq_agg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pend_i,
  input  logic           rd_en_i,
  output logic [NCH-1:0] snap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      snap_o <= '0;
    else if (rd_en_i) snap_o <= pend_i;
  end

  a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> snap_o == $past(pend_i));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(snap_o));
endmodule

// File: rtl/sel_reg.sv
module sel_reg
  import irq_agg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [SELW-1:0] wr_sel_i,
  output logic [SELW-1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_o <= '0;
    else if (wr_en_i) sel_o <= wr_sel_i;
  end

  a_r6_sel_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(sel_o));
  a_r6_sel_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> sel_o == $past(wr_sel_i));
endmodule

// File: rtl/irq_fanin_agg.sv
module irq_fanin_agg
  import irq_agg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   irq_ni,
  output logic             irq_no,
  input  logic             wr_en_i,
  input  logic [BYTEW-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [BYTEW-1:0] rd_data_o,
  output logic             chan_en_o,
  output logic [CHW-1:0]   chan_sel_o
);
  logic [NCH-1:0]  irq_sync_n;
  logic [NCH-1:0]  pend;
  logic [NCH-1:0]  snap;
  logic [SELW-1:0] sel;

  irq_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_ni),
    .q_o   (irq_sync_n)
  );

  assign pend   = ~irq_sync_n;
  assign irq_no = ~|pend;

  irq_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .rd_en_i(rd_en_i),
    .snap_o (snap)
  );

  sel_reg u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wr_sel_i(wr_data_i[SELW-1:0]),
    .sel_o   (sel)
  );

  assign rd_data_o  = {snap, {PADW{1'b0}}, sel};
  assign chan_en_o  = sel[SELW-1];
  assign chan_sel_o = sel[CHW-1:0];

  // edges since reset, saturating; gates the two-deep history checks
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r2_assert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && !(&$past(irq_ni, 2))) |-> !irq_no);
  a_r3_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && (&$past(irq_ni, 2))) |-> irq_no);
endmodule

// File: tb/sim_irq_fanin_agg.sv
module sim_irq_fanin_agg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq_n = 4'hF;
  logic       irq_o;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       ch_en;
  logic [1:0] ch_sel;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  irq_fanin_agg u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_ni(irq_n), .irq_no(irq_o),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .chan_en_o(ch_en), .chan_sel_o(ch_sel)
  );

  // {irq_n[3:0], write byte[7:0], expected pending nibble[3:0], expected irq_no}
  localparam logic [16:0] VEC [8] = '{
    {4'b1111, 8'h00, 4'b0000, 1'b1},
    {4'b1110, 8'h04, 4'b0001, 1'b0},
    {4'b1101, 8'h04, 4'b0010, 1'b0},
    {4'b1011, 8'hF5, 4'b0100, 1'b0},
    {4'b0111, 8'h0E, 4'b1000, 1'b0},
    {4'b0000, 8'h07, 4'b1111, 1'b0},
    {4'b1010, 8'h03, 4'b0101, 1'b0},
    {4'b1111, 8'h00, 4'b0000, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    edges(3);
    // R1: reset state
    chk("R1 irq_no", {7'd0, irq_o}, 8'h01);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 chan", {5'd0, ch_en, ch_sel}, 8'h00);
    rst_n = 1'b1;
    edges(2);

    for (int i = 0; i < 8; i++) begin
      irq_n = VEC[i][16:13];
      edges(1);
      // R2: one edge in, not yet visible
      if (VEC[i][0] == 1'b0 && i > 0 && VEC[i-1][0] == 1'b1)
        chk("R2 latency", {7'd0, irq_o}, 8'h01);
      edges(1);
      chk(VEC[i][0] ? "R3 irq_no" : "R2 irq_no", {7'd0, irq_o}, {7'd0, VEC[i][0]});
      rd_en = 1'b1; wr_en = 1'b1; wr_data = VEC[i][12:5];
      edges(1);
      rd_en = 1'b0; wr_en = 1'b0;
      chk("R4/R6 rd_data", rd_data, {VEC[i][4:1], 1'b0, VEC[i][7:5]});
      chk("R7 chan", {5'd0, ch_en, ch_sel}, {5'd0, VEC[i][7:5]});
    end

    // R5: snapshot holds while inputs change
    irq_n = 4'b0110;
    edges(4);
    chk("R5 hold", rd_data, 8'h00);
    chk("R2 unselected", {7'd0, irq_o}, 8'h00);
    rd_en = 1'b1;
    edges(1);
    rd_en = 1'b0;
    chk("R4 capture", rd_data, 8'h90);
    // R3: release without a read
    irq_n = 4'hF;
    edges(1);
    chk("R3 still low", {7'd0, irq_o}, 8'h00);
    edges(1);
    chk("R3 release", {7'd0, irq_o}, 8'h01);
    chk("R5 after release", rd_data, 8'h90);

    // R6: write with no read leaves status, bit3 zero
    wr_en = 1'b1; wr_data = 8'h6D;
    edges(1);
    wr_en = 1'b0;
    chk("R6 write only", rd_data, 8'h95);
    chk("R7 chan", {5'd0, ch_en, ch_sel}, 8'h05);

    // R1: reset mid-run clears select and snapshot
    rst_n = 1'b0;
    edges(1);
    chk("R1 re-reset", rd_data, 8'h00);
    chk("R1 re-reset chan", {5'd0, ch_en, ch_sel}, 8'h00);
    rst_n = 1'b1;
    edges(1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule